// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block sits between a core and a single external address/data bus. In one cycle the core may post up to three accesses: a data write, a data read and a program fetch. The writes and reads may target either data space or I/O space. The sequencer latches the posted accesses and plays them out one after another on the shared bus. It always takes them in the fixed order write, then read, then fetch.

Each access raises exactly one of three space-select strobes. It then holds that strobe and the address for a number of wait states taken from a 12-bit configuration word. Data accesses that land in the global part of the upper half of data space also pull an active-low global strobe. The core is stalled until every posted access has completed. Each access returns a one-cycle completion pulse, and reads and fetches return the captured data with it.

Top module: `xbus_seq`

## Requirements
- R1: After reset all space strobes, `bus_oe_o`, `stall_o` and the completion pulses are 0, and `gbl_no` is 1.
- R2: While an access is on the bus exactly one strobe is high: `prog_sel_o` for fetches, `data_sel_o` for reads and writes with the I/O flag 0, and `io_sel_o` for reads and writes with the I/O flag 1.
- R3: Accesses posted together appear on the bus in the order write, read, fetch. Each access follows the previous one with no idle cycle, and the first starts in the cycle after posting.
- R4: An access with wait-state value w holds its strobe and its address for exactly w+1 cycles.
- R5: The wait-state value comes from `ws_cfg_i` as follows. Bits [2:0] apply to fetches with address bit 15 = 0. Bits [5:3] apply to fetches with address bit 15 = 1. Bits [8:6] apply to data-space accesses and bits [11:9] to I/O accesses.
- R6: Let n be the number of consecutive ones in `gbl_map_i` counted down from bit 7. `gbl_no` is low during a data-space access exactly when address bit 15 = 1 and address bits [14:12] ≥ 8−n. It stays high for program and I/O accesses.
- R7: `stall_o` is high in the posting cycle and through the whole sequence. It falls in the cycle after the last access ends, which is the cycle that carries that access's completion pulse.
- R8: `bus_oe_o` is high only during write accesses, and `bus_wdata_o` carries the write data then. At all other times `bus_wdata_o` is 0.
- R9: A read or fetch captures `bus_rdata_i` in its final wait cycle. It then shows that value on `rd_data_o`/`pf_data_o` together with a one-cycle `rd_done_o`/`pf_done_o` pulse in the next cycle. A write pulses `wr_done_o` in the same way.
- R10: Request inputs are ignored while any posted access is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Post a write (one cycle) |
| wr_io_i | input | 1 | Write targets I/O space |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_req_i | input | 1 | Post a read (one cycle) |
| rd_io_i | input | 1 | Read targets I/O space |
| rd_addr_i | input | 16 | Read address |
| pf_req_i | input | 1 | Post a program fetch (one cycle) |
| pf_addr_i | input | 16 | Fetch address |
| ws_cfg_i | input | 12 | Wait-state configuration, four 3-bit fields |
| gbl_map_i | input | 8 | Global-region mask (leading ones) |
| bus_addr_o | output | 16 | External address |
| bus_wdata_o | output | 16 | External write data |
| bus_oe_o | output | 1 | Write data drive enable |
| bus_rdata_i | input | 16 | External read data |
| prog_sel_o | output | 1 | Program space strobe |
| data_sel_o | output | 1 | Data space strobe |
| io_sel_o | output | 1 | I/O space strobe |
| gbl_no | output | 1 | Global data access strobe, active low |
| stall_o | output | 1 | Core stall |
| wr_done_o | output | 1 | Write completed |
| rd_done_o | output | 1 | Read completed |
| rd_data_o | output | 16 | Read data |
| pf_done_o | output | 1 | Fetch completed |
| pf_data_o | output | 16 | Fetch data |

## Verification
A corrupt pending mask or channel register shows up in the first bus cycle after posting. The wrong strobe or address appears, or an access runs out of order. A wait counter loaded from the wrong field lengthens or shortens a strobe, and the next access then starts a cycle early or late. A faulty global decode shows on `gbl_no` in the same cycle the address appears. A lost pending bit either drops `stall_o` one access too soon or leaves it high after the last completion pulse.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {CH_WR = 2'd0, CH_RD = 2'd1, CH_PF = 2'd2} chan_e;
  typedef enum logic [1:0] {SP_PROG = 2'd0, SP_DATA = 2'd1, SP_IO = 2'd2} space_e;
  localparam int NCH = 3;
endpackage

// File: rtl/xbus_pick.sv
module xbus_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  // lowest index wins: write, read, fetch
  for (genvar i = 0; i < N; i++) begin : g_grant
    if (i == 0) begin : g_first
      assign grant_o[i] = req_i[i];
    end else begin : g_rest
      assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
    end
  end
endmodule

// File: rtl/xbus_ws_sel.sv
module xbus_ws_sel
  import xbus_pkg::*;
#(
  parameter int WSW = 3
) (
  input  space_e             space_i,
  input  logic               hi_i,
  input  logic [4*WSW-1:0]   cfg_i,
  output logic [WSW-1:0]     ws_o
);
  always_comb begin
    unique case (space_i)
      SP_PROG: ws_o = hi_i ? cfg_i[2*WSW-1:WSW] : cfg_i[WSW-1:0];
      SP_DATA: ws_o = cfg_i[3*WSW-1:2*WSW];
      SP_IO:   ws_o = cfg_i[4*WSW-1:3*WSW];
      default: ws_o = '0;
    endcase
  end
endmodule

// File: rtl/xbus_glob_chk.sv
module xbus_glob_chk #(
  parameter int GMW = 8,
  localparam int IW = $clog2(GMW),
  localparam int CW = $clog2(GMW + 1)
) (
  input  logic [GMW-1:0] map_i,
  input  logic [IW:0]    addr_top_i,  // address MSB + region index
  input  logic           is_data_i,
  output logic           glob_o
);
  logic [CW-1:0] ones;
  logic          run;
  logic [CW-1:0] idx;
  logic [CW-1:0] floor_idx;

  always_comb begin
    ones = '0;
    run  = 1'b1;
    for (int i = GMW - 1; i >= 0; i--) begin
      if (run && map_i[i]) ones = ones + 1'b1;
      else run = 1'b0;
    end
  end

  assign idx       = CW'(addr_top_i[IW-1:0]);
  assign floor_idx = CW'(GMW) - ones;
  assign glob_o    = is_data_i & addr_top_i[IW] & (idx >= floor_idx);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WSW = 3,
  parameter int GMW = 8,
  localparam int IW = $clog2(GMW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic             wr_io_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_req_i,
  input  logic             rd_io_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic             pf_req_i,
  input  logic [AW-1:0]    pf_addr_i,
  input  logic [4*WSW-1:0] ws_cfg_i,
  input  logic [GMW-1:0]   gbl_map_i,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_wdata_o,
  output logic             bus_oe_o,
  input  logic [DW-1:0]    bus_rdata_i,
  output logic             prog_sel_o,
  output logic             data_sel_o,
  output logic             io_sel_o,
  output logic             gbl_no,
  output logic             stall_o,
  output logic             wr_done_o,
  output logic             rd_done_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             pf_done_o,
  output logic [DW-1:0]    pf_data_o
);
  logic [NCH-1:0] pend_q, done_q, req_vec, cur_bit, rest, pick_src, grant;
  logic           act_q, idle, last, cur_glob;
  chan_e          ch_q, nxt_ch;
  logic [WSW-1:0] cnt_q, nxt_ws;
  logic [AW-1:0]  wr_addr_q, rd_addr_q, pf_addr_q, nxt_addr, cur_addr;
  logic [DW-1:0]  wr_data_q, rd_data_q, pf_data_q;
  logic           wr_io_q, rd_io_q;
  space_e         nxt_space, cur_space;

  assign req_vec  = {pf_req_i, rd_req_i, wr_req_i};
  assign idle     = ~(|pend_q);
  assign cur_bit  = NCH'(1) << ch_q;
  assign rest     = pend_q & ~cur_bit;
  assign last     = act_q && (cnt_q == '0);
  assign pick_src = idle ? req_vec : rest;

  xbus_pick #(.N(NCH)) u_pick (.req_i(pick_src), .grant_o(grant));

  always_comb begin
    if (grant[0])      nxt_ch = CH_WR;
    else if (grant[1]) nxt_ch = CH_RD;
    else               nxt_ch = CH_PF;
  end

  // next access attributes: from inputs when idle, else latched copies
  always_comb begin
    unique case (nxt_ch)
      CH_WR: begin
        nxt_addr  = idle ? wr_addr_i : wr_addr_q;
        nxt_space = (idle ? wr_io_i : wr_io_q) ? SP_IO : SP_DATA;
      end
      CH_RD: begin
        nxt_addr  = idle ? rd_addr_i : rd_addr_q;
        nxt_space = (idle ? rd_io_i : rd_io_q) ? SP_IO : SP_DATA;
      end
      default: begin
        nxt_addr  = idle ? pf_addr_i : pf_addr_q;
        nxt_space = SP_PROG;
      end
    endcase
  end

  xbus_ws_sel #(.WSW(WSW)) u_ws (
    .space_i (nxt_space),
    .hi_i    (nxt_addr[AW-1]),
    .cfg_i   (ws_cfg_i),
    .ws_o    (nxt_ws)
  );

  always_comb begin
    unique case (ch_q)
      CH_WR: begin
        cur_addr  = wr_addr_q;
        cur_space = wr_io_q ? SP_IO : SP_DATA;
      end
      CH_RD: begin
        cur_addr  = rd_addr_q;
        cur_space = rd_io_q ? SP_IO : SP_DATA;
      end
      default: begin
        cur_addr  = pf_addr_q;
        cur_space = SP_PROG;
      end
    endcase
  end

  xbus_glob_chk #(.GMW(GMW)) u_glob (
    .map_i      (gbl_map_i),
    .addr_top_i (cur_addr[AW-1 -: IW+1]),
    .is_data_i  (act_q && cur_space == SP_DATA),
    .glob_o     (cur_glob)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      done_q    <= '0;
      act_q     <= 1'b0;
      ch_q      <= CH_WR;
      cnt_q     <= '0;
      wr_addr_q <= '0;
      rd_addr_q <= '0;
      pf_addr_q <= '0;
      wr_data_q <= '0;
      wr_io_q   <= 1'b0;
      rd_io_q   <= 1'b0;
      rd_data_q <= '0;
      pf_data_q <= '0;
    end else begin
      done_q <= '0;
      if (idle && |req_vec) begin
        pend_q    <= req_vec;
        wr_addr_q <= wr_addr_i;
        wr_data_q <= wr_data_i;
        wr_io_q   <= wr_io_i;
        rd_addr_q <= rd_addr_i;
        rd_io_q   <= rd_io_i;
        pf_addr_q <= pf_addr_i;
        act_q     <= 1'b1;
        ch_q      <= nxt_ch;
        cnt_q     <= nxt_ws;
      end else if (act_q) begin
        if (last) begin
          pend_q <= rest;
          done_q <= cur_bit;
          if (ch_q == CH_RD) rd_data_q <= bus_rdata_i;
          if (ch_q == CH_PF) pf_data_q <= bus_rdata_i;
          if (|rest) begin
            ch_q  <= nxt_ch;
            cnt_q <= nxt_ws;
          end else begin
            act_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign bus_addr_o  = act_q ? cur_addr : '0;
  assign bus_oe_o    = act_q && ch_q == CH_WR;
  assign bus_wdata_o = bus_oe_o ? wr_data_q : '0;
  assign prog_sel_o  = act_q && cur_space == SP_PROG;
  assign data_sel_o  = act_q && cur_space == SP_DATA;
  assign io_sel_o    = act_q && cur_space == SP_IO;
  assign gbl_no      = ~cur_glob;
  assign stall_o     = ~idle | (|req_vec);
  assign wr_done_o   = done_q[CH_WR];
  assign rd_done_o   = done_q[CH_RD];
  assign pf_done_o   = done_q[CH_PF];
  assign rd_data_o   = rd_data_q;
  assign pf_data_o   = pf_data_q;
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WSW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           prog_sel_o,
  input logic           data_sel_o,
  input logic           io_sel_o,
  input logic           gbl_no,
  input logic           bus_oe_o,
  input logic [DW-1:0]  bus_wdata_o,
  input logic [AW-1:0]  bus_addr_o,
  input logic           stall_o,
  input logic           wr_done_o,
  input logic           rd_done_o,
  input logic           pf_done_o,
  input logic [2:0]     pend_q,
  input logic           act_q,
  input logic [WSW-1:0] cnt_q
);
  a_r2_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_sel_o, data_sel_o, io_sel_o}));

  a_r2_strobe_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> $countones({prog_sel_o, data_sel_o, io_sel_o}) == 1);

  a_r3_fetch_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_sel_o |-> !pend_q[0] && !pend_q[1]);

  a_r4_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && cnt_q != '0) |=> $stable(bus_addr_o) && $stable({prog_sel_o, data_sel_o, io_sel_o}));

  a_r6_glob_data_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gbl_no |-> data_sel_o);

  a_r7_stall_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> (wr_done_o || rd_done_o || pf_done_o));

  a_r8_quiet_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> bus_wdata_o == '0);

  a_r8_oe_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (data_sel_o || io_sel_o));
endmodule

bind xbus_seq xbus_seq_chk #(.AW(AW), .DW(DW), .WSW(WSW)) u_chk (.*);

// File: tb/xbus_seq_test.sv
`timescale 1ns/1ps
module xbus_seq_test;
  localparam logic [2:0] S_PROG = 3'b100, S_DATA = 3'b010, S_IO = 3'b001;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_req = 0, wr_io = 0, rd_req = 0, rd_io = 0, pf_req = 0;
  logic [15:0] wr_addr = 0, wr_data = 0, rd_addr = 0, pf_addr = 0;
  logic [11:0] ws_cfg = 0;
  logic [7:0]  gmap = 0;
  logic [15:0] bus_addr, bus_wdata, bus_rdata, rd_data, pf_data;
  logic        bus_oe, psel, dsel, isel, gbl_n, stall, wr_done, rd_done, pf_done;

  int n_chk = 0, n_bad = 0;
  int n_wr = 0, n_rd = 0, n_pf = 0;
  logic [15:0] rd_last = 0, pf_last = 0;

  always #10 clk = ~clk;
  assign bus_rdata = bus_addr ^ 16'h5A5A;

  xbus_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_req_i(wr_req), .wr_io_i(wr_io), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .rd_io_i(rd_io), .rd_addr_i(rd_addr),
    .pf_req_i(pf_req), .pf_addr_i(pf_addr),
    .ws_cfg_i(ws_cfg), .gbl_map_i(gmap),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_oe_o(bus_oe), .bus_rdata_i(bus_rdata),
    .prog_sel_o(psel), .data_sel_o(dsel), .io_sel_o(isel), .gbl_no(gbl_n),
    .stall_o(stall), .wr_done_o(wr_done), .rd_done_o(rd_done), .rd_data_o(rd_data),
    .pf_done_o(pf_done), .pf_data_o(pf_data)
  );

  always @(negedge clk) begin
    if (wr_done) n_wr++;
    if (rd_done) begin n_rd++; rd_last = rd_data; end
    if (pf_done) begin n_pf++; pf_last = pf_data; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic post(input bit w, input bit r, input bit p,
                      input logic [15:0] wa, input logic [15:0] wd, input bit wio,
                      input logic [15:0] ra, input bit rio, input logic [15:0] pa);
    @(negedge clk);
    wr_req = w; wr_addr = wa; wr_data = wd; wr_io = wio;
    rd_req = r; rd_addr = ra; rd_io = rio;
    pf_req = p; pf_addr = pa;
    #1;
    chk(stall === 1'b1, "R7", "stall on post", 32'(stall), 1);
    @(negedge clk);
    wr_req = 0; rd_req = 0; pf_req = 0;
  endtask

  // checks one access for ws+1 cycles, starting at the current negedge
  task automatic expect_access(input logic [2:0] sp, input logic [15:0] addr, input int ws,
                               input bit glob, input bit is_wr, input logic [15:0] wd,
                               input string req);
    for (int i = 0; i <= ws; i++) begin
      chk({psel, dsel, isel} === sp, req, "strobe", 32'({psel, dsel, isel}), 32'(sp));
      chk(bus_addr === addr, req, "addr", 32'(bus_addr), 32'(addr));
      chk(gbl_n === !glob, "R6", "global strobe", 32'(gbl_n), 32'(!glob));
      chk(bus_oe === is_wr, "R8", "drive enable", 32'(bus_oe), 32'(is_wr));
      chk(bus_wdata === (is_wr ? wd : 16'h0), "R8", "write data", 32'(bus_wdata),
          32'(is_wr ? wd : 16'h0));
      chk(stall === 1'b1, "R7", "stall held", 32'(stall), 1);
      @(negedge clk);
    end
  endtask

  task automatic seq_end();
    chk(stall === 1'b0, "R7", "stall released", 32'(stall), 0);
    chk({psel, dsel, isel} === 3'b000, "R3", "bus idle", 32'({psel, dsel, isel}), 0);
  endtask

  task automatic t_reset();
    chk({psel, dsel, isel, bus_oe, stall} === 5'b0, "R1", "outputs low",
        32'({psel, dsel, isel, bus_oe, stall}), 0);
    chk(gbl_n === 1'b1, "R1", "global strobe idle", 32'(gbl_n), 1);
    chk({wr_done, rd_done, pf_done} === 3'b0, "R1", "no completions",
        32'({wr_done, rd_done, pf_done}), 0);
  endtask

  task automatic t_order_fast();
    int w0 = n_wr, r0 = n_rd, p0 = n_pf;
    ws_cfg = 12'h000; gmap = 8'h00;
    post(1, 1, 1, 16'h0123, 16'hBEEF, 0, 16'h0456, 0, 16'h0789);
    expect_access(S_DATA, 16'h0123, 0, 0, 1, 16'hBEEF, "R3");
    expect_access(S_DATA, 16'h0456, 0, 0, 0, 16'h0, "R3");
    expect_access(S_PROG, 16'h0789, 0, 0, 0, 16'h0, "R3");
    seq_end();
    chk(pf_done === 1'b1, "R9", "fetch done with stall release", 32'(pf_done), 1);
    @(negedge clk);
    chk(n_wr == w0 + 1, "R9", "write done count", 32'(n_wr - w0), 1);
    chk(n_rd == r0 + 1, "R9", "read done count", 32'(n_rd - r0), 1);
    chk(n_pf == p0 + 1, "R9", "fetch done count", 32'(n_pf - p0), 1);
    chk(rd_last === (16'h0456 ^ 16'h5A5A), "R9", "read data", 32'(rd_last), 32'(16'h0456 ^ 16'h5A5A));
    chk(pf_last === (16'h0789 ^ 16'h5A5A), "R9", "fetch data", 32'(pf_last), 32'(16'h0789 ^ 16'h5A5A));
  endtask

  task automatic t_order_slow();
    ws_cfg = 12'hFFF; gmap = 8'h00;
    post(1, 1, 1, 16'h8001, 16'h1357, 1, 16'h8002, 0, 16'hC003);
    expect_access(S_IO,   16'h8001, 7, 0, 1, 16'h1357, "R4");
    expect_access(S_DATA, 16'h8002, 7, 0, 0, 16'h0, "R4");
    expect_access(S_PROG, 16'hC003, 7, 0, 0, 16'h0, "R4");
    seq_end();
    @(negedge clk);
    chk(rd_last === (16'h8002 ^ 16'h5A5A), "R9", "slow read data", 32'(rd_last), 32'(16'h8002 ^ 16'h5A5A));
  endtask

  task automatic t_fields();
    ws_cfg = 12'b100_011_010_001; gmap = 8'h00;
    post(0, 0, 1, 0, 0, 0, 0, 0, 16'h1000);
    expect_access(S_PROG, 16'h1000, 1, 0, 0, 0, "R5");
    seq_end();
    post(0, 0, 1, 0, 0, 0, 0, 0, 16'h9000);
    expect_access(S_PROG, 16'h9000, 2, 0, 0, 0, "R5");
    seq_end();
    post(0, 1, 0, 0, 0, 0, 16'h2222, 0, 0);
    expect_access(S_DATA, 16'h2222, 3, 0, 0, 0, "R5");
    seq_end();
    post(1, 1, 0, 16'h0044, 16'hA0A0, 1, 16'h0055, 1, 0);
    expect_access(S_IO, 16'h0044, 4, 0, 1, 16'hA0A0, "R5");
    expect_access(S_IO, 16'h0055, 4, 0, 0, 0, "R2");
    seq_end();
  endtask

  task automatic t_global();
    ws_cfg = 12'h000;
    gmap = 8'hE0;  // n=3: index >= 5
    post(1, 1, 1, 16'hD000, 16'h0F0F, 0, 16'hCFFF, 0, 16'hF000);
    expect_access(S_DATA, 16'hD000, 0, 1, 1, 16'h0F0F, "R6");
    expect_access(S_DATA, 16'hCFFF, 0, 0, 0, 0, "R6");
    expect_access(S_PROG, 16'hF000, 0, 0, 0, 0, "R6");
    seq_end();
    gmap = 8'hFF;
    post(1, 1, 0, 16'hFFFF, 16'h0001, 1, 16'h8000, 0, 0);
    expect_access(S_IO,   16'hFFFF, 0, 0, 1, 16'h0001, "R6");
    expect_access(S_DATA, 16'h8000, 0, 1, 0, 0, "R6");
    seq_end();
    post(0, 1, 0, 0, 0, 0, 16'h7FFF, 0, 0);
    expect_access(S_DATA, 16'h7FFF, 0, 0, 0, 0, "R6");
    seq_end();
    gmap = 8'h0F;  // no leading ones
    post(0, 1, 0, 0, 0, 0, 16'hF000, 0, 0);
    expect_access(S_DATA, 16'hF000, 0, 0, 0, 0, "R6");
    seq_end();
    gmap = 8'h80;
    post(0, 1, 0, 0, 0, 0, 16'hF000, 0, 0);
    expect_access(S_DATA, 16'hF000, 0, 1, 0, 0, "R6");
    seq_end();
    post(0, 1, 0, 0, 0, 0, 16'hEFFF, 0, 0);
    expect_access(S_DATA, 16'hEFFF, 0, 0, 0, 0, "R6");
    seq_end();
  endtask

  task automatic t_ignore();
    int r0;
    ws_cfg = 12'h0C0; gmap = 8'h00;
    post(1, 0, 0, 16'h0010, 16'h7777, 0, 0, 0, 0);
    r0 = n_rd;
    rd_req = 1; rd_addr = 16'h0020; rd_io = 0;
    expect_access(S_DATA, 16'h0010, 3, 0, 1, 16'h7777, "R10");
    rd_req = 0;
    #1;
    chk(stall === 1'b0, "R10", "stall after ignored request", 32'(stall), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk({psel, dsel, isel} === 3'b000, "R10", "no access started", 32'({psel, dsel, isel}), 0);
    end
    chk(n_rd == r0, "R10", "no read completion", 32'(n_rd - r0), 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_fast();
    t_order_slow();
    t_fields();
    t_global();
    t_ignore();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule